// File: doc/BRIEF.md
# Lockstep Bus Compare Monitor

This block sits between two processor cores that run the same program in lockstep and the rest of the chip. It watches the bus interface of each core. Only the master core's bus goes on to memory and system outputs. The checker core's bus is watched and never forwarded. In every cycle where either core asserts its bus-valid line, the block compares the control, address and write-data lines of the two interfaces. It also checks even parity on the read data that memory returns to both cores. Parity is needed because an error on that shared path reaches both cores in the same way, so comparing the cores cannot reveal it.

Any disagreement or parity error blocks the master's output strobes in that same cycle. It also sets a fault flag from the next clock edge onward, and the flag stays set until reset, so the node stays silent. A mismatch does not say which core is faulty. A class register records the kind of line that caused the first fault: control, address, data or parity. The address, data and control fields of the master bus are always passed through unchanged. Only the valid and write strobes are blocked.

Top module: `lockstep_compare_monitor`

## Requirements
- R1: After reset, faultFlag is 0 and faultClass is 0 (none).
- R2: While no mismatch or parity error has occurred since reset, outValid, outWrite, outAddr, outWdata and outCtrl equal the master's bus lines, and the checker's lines are never forwarded.
- R3: In a cycle where mstValid, chkValid and shRdValid are all low, differences between the two interfaces' address, data, write and control lines cause no fault.
- R4: When both valids are high, control and write agree, and the addresses differ, faultFlag is 1 after the next rising edge and faultClass is 1 (address).
- R5: When both cores are writing with the same address and control but different write data, faultClass becomes 2 (data). Write data is not compared on reads (write low on both).
- R6: A control mismatch sets faultClass to 3 (control). A control mismatch is mstValid differing from chkValid, or, with both valid, a difference in the write bit or in the CTRL_W-bit control field.
- R7: When shRdValid is high, byte lane i of shRdData (bits 8i+7..8i) together with shRdPar[i] must have even parity. Any lane that fails sets faultClass to 4 (parity), even when the two cores agree.
- R8: In the cycle a mismatch or parity error is present, outValid and outWrite are already low.
- R9: Once faultFlag is set, it stays 1 and outValid and outWrite stay low until reset, whatever the later traffic.
- R10: faultClass keeps the class of the first fault. Later mismatches of other classes do not change it.
- R11: If several classes occur in the same cycle, the recorded class follows the priority control > address > data > parity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| mstValid | input | 1 | Master bus cycle valid |
| mstWrite | input | 1 | Master write (1) / read (0) |
| mstAddr | input | ADDR_W | Master address |
| mstWdata | input | DATA_W | Master write data |
| mstCtrl | input | CTRL_W | Master control field (size, attributes) |
| chkValid | input | 1 | Checker bus cycle valid |
| chkWrite | input | 1 | Checker write / read |
| chkAddr | input | ADDR_W | Checker address |
| chkWdata | input | DATA_W | Checker write data |
| chkCtrl | input | CTRL_W | Checker control field |
| shRdValid | input | 1 | Shared read-return data valid |
| shRdData | input | DATA_W | Shared read data fed to both cores |
| shRdPar | input | DATA_W/8 | Even parity bit per byte lane of shRdData |
| outValid | output | 1 | Forwarded master valid, gated by fault |
| outWrite | output | 1 | Forwarded master write strobe, gated by fault |
| outAddr | output | ADDR_W | Forwarded master address |
| outWdata | output | DATA_W | Forwarded master write data |
| outCtrl | output | CTRL_W | Forwarded master control field |
| faultFlag | output | 1 | Sticky fault indication |
| faultClass | output | 3 | Class of first fault: 0 none, 1 address, 2 data, 3 control, 4 parity |

## Verification
If the fault register were lost or cleared, outValid and outWrite would reappear on the ports in the first matching bus cycle after a fault. A wrong priority or a class register that gets overwritten would show up on faultClass one edge after the second, conflicting mismatch. A missing combinational silence path would let a strobe through in exactly the diverging cycle. For that reason every cycle is sampled between clock edges, and the strobes and fault state are compared against an independent model of the first-fault rules.

// File: rtl/lcm_pkg.sv
package lcm_pkg;

  // Fault class codes reported on faultClass
  typedef enum logic [2:0] {
    CLS_NONE = 3'd0,
    CLS_ADDR = 3'd1,
    CLS_DATA = 3'd2,
    CLS_CTRL = 3'd3,
    CLS_PAR  = 3'd4
  } faultClass_e;

  // Per-cycle disagreement indications from the datapath
  typedef struct packed {
    logic ctrlHit;
    logic addrHit;
    logic dataHit;
    logic parHit;
  } hitVec_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic silence;
  } ctlStrobe_t;

endpackage

// File: rtl/lcm_parity.sv
module lcm_parity #(
  parameter int LANE_W = 8
) (
  input  logic              en,
  input  logic [LANE_W-1:0] laneData,
  input  logic              laneParBit,
  output logic              laneErr
);

  // Even parity: data bits plus parity bit must contain an even number of ones
  assign laneErr = en & ((^laneData) ^ laneParBit);

endmodule

// File: rtl/lcm_datapath.sv
module lcm_datapath
  import lcm_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CTRL_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              mstValid,
  input  logic              mstWrite,
  input  logic [ADDR_W-1:0] mstAddr,
  input  logic [DATA_W-1:0] mstWdata,
  input  logic [CTRL_W-1:0] mstCtrl,
  input  logic              chkValid,
  input  logic              chkWrite,
  input  logic [ADDR_W-1:0] chkAddr,
  input  logic [DATA_W-1:0] chkWdata,
  input  logic [CTRL_W-1:0] chkCtrl,
  input  logic              shRdValid,
  input  logic [DATA_W-1:0] shRdData,
  input  logic [DATA_W/8-1:0] shRdPar,
  input  ctlStrobe_t        strobe,
  output hitVec_t           hits,
  output logic [2:0]        faultClass
);

  localparam int LANE_W = 8;
  localparam int LANES  = DATA_W / LANE_W;

  logic             bothValid;
  logic             ctrlDiff;
  logic [LANES-1:0] laneErr;
  faultClass_e      nextClass;
  faultClass_e      classQ;

  assign bothValid = mstValid & chkValid;
  assign ctrlDiff  = (mstWrite != chkWrite) | (mstCtrl != chkCtrl);

  // One parity checker per byte lane of the shared read path
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    lcm_parity #(.LANE_W(LANE_W)) u_par (
      .en        (shRdValid),
      .laneData  (shRdData[g*LANE_W +: LANE_W]),
      .laneParBit(shRdPar[g]),
      .laneErr   (laneErr[g])
    );
  end

  always_comb begin
    hits.ctrlHit = (mstValid != chkValid) | (bothValid & ctrlDiff);
    hits.addrHit = bothValid & (mstAddr != chkAddr);
    hits.dataHit = bothValid & mstWrite & chkWrite & (mstWdata != chkWdata);
    hits.parHit  = |laneErr;
  end

  // Priority: control, address, data, parity
  always_comb begin
    if (hits.ctrlHit)      nextClass = CLS_CTRL;
    else if (hits.addrHit) nextClass = CLS_ADDR;
    else if (hits.dataHit) nextClass = CLS_DATA;
    else if (hits.parHit)  nextClass = CLS_PAR;
    else                   nextClass = CLS_NONE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              classQ <= CLS_NONE;
    else if (strobe.capture) classQ <= nextClass;
  end

  assign faultClass = classQ;

  AST_CLASS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (classQ != CLS_NONE) |=> $stable(classQ)); // R10

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!mstValid && !chkValid && !shRdValid) |-> (hits == '0)); // R3

endmodule

// File: rtl/lcm_control.sv
module lcm_control
  import lcm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  hitVec_t    hits,
  output ctlStrobe_t strobe,
  output logic       faultFlag
);

  logic anyHit;
  logic faultQ;

  assign anyHit = |hits;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       faultQ <= 1'b0;
    else if (anyHit) faultQ <= 1'b1;
  end

  always_comb begin
    strobe.capture = anyHit & ~faultQ;
    strobe.silence = anyHit | faultQ;
  end

  assign faultFlag = faultQ;

  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    faultQ |=> faultQ); // R9

  AST_DETECT_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    anyHit |=> faultQ); // R4

endmodule

// File: rtl/lockstep_compare_monitor.sv
module lockstep_compare_monitor
  import lcm_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CTRL_W = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                mstValid,
  input  logic                mstWrite,
  input  logic [ADDR_W-1:0]   mstAddr,
  input  logic [DATA_W-1:0]   mstWdata,
  input  logic [CTRL_W-1:0]   mstCtrl,
  input  logic                chkValid,
  input  logic                chkWrite,
  input  logic [ADDR_W-1:0]   chkAddr,
  input  logic [DATA_W-1:0]   chkWdata,
  input  logic [CTRL_W-1:0]   chkCtrl,
  input  logic                shRdValid,
  input  logic [DATA_W-1:0]   shRdData,
  input  logic [DATA_W/8-1:0] shRdPar,
  output logic                outValid,
  output logic                outWrite,
  output logic [ADDR_W-1:0]   outAddr,
  output logic [DATA_W-1:0]   outWdata,
  output logic [CTRL_W-1:0]   outCtrl,
  output logic                faultFlag,
  output logic [2:0]          faultClass
);

  hitVec_t    hits;
  ctlStrobe_t strobe;

  lcm_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_W(CTRL_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .mstValid  (mstValid),
    .mstWrite  (mstWrite),
    .mstAddr   (mstAddr),
    .mstWdata  (mstWdata),
    .mstCtrl   (mstCtrl),
    .chkValid  (chkValid),
    .chkWrite  (chkWrite),
    .chkAddr   (chkAddr),
    .chkWdata  (chkWdata),
    .chkCtrl   (chkCtrl),
    .shRdValid (shRdValid),
    .shRdData  (shRdData),
    .shRdPar   (shRdPar),
    .strobe    (strobe),
    .hits      (hits),
    .faultClass(faultClass)
  );

  lcm_control u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .hits     (hits),
    .strobe   (strobe),
    .faultFlag(faultFlag)
  );

  // Only the master bus is forwarded; strobes are blocked on any fault
  assign outValid = mstValid & ~strobe.silence;
  assign outWrite = mstWrite & ~strobe.silence;
  assign outAddr  = mstAddr;
  assign outWdata = mstWdata;
  assign outCtrl  = mstCtrl;

  AST_SILENT_AFTER_FAULT: assert property (@(posedge clk) disable iff (!rstN)
    faultFlag |-> (!outValid && !outWrite)); // R9

  AST_CLASS_WITH_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (faultClass != 3'd0) == faultFlag); // R1

endmodule

// File: tb/lockstep_compare_monitor_bench.sv
module lockstep_compare_monitor_bench;

  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int CTRL_W = 4;
  localparam int LANES  = DATA_W / 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mstValid, mstWrite, chkValid, chkWrite, shRdValid;
  logic [ADDR_W-1:0] mstAddr, chkAddr, outAddr;
  logic [DATA_W-1:0] mstWdata, chkWdata, shRdData, outWdata;
  logic [CTRL_W-1:0] mstCtrl, chkCtrl, outCtrl;
  logic [LANES-1:0]  shRdPar;
  logic outValid, outWrite, faultFlag;
  logic [2:0] faultClass;

  int nVec = 0;
  int nFail = 0;
  logic expFault = 1'b0;
  logic [2:0] expCls = 3'd0;

  always #4 clk = ~clk;

  lockstep_compare_monitor #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_W(CTRL_W)) u_lockstep_compare_monitor (
    .clk(clk), .rstN(rstN),
    .mstValid(mstValid), .mstWrite(mstWrite), .mstAddr(mstAddr), .mstWdata(mstWdata), .mstCtrl(mstCtrl),
    .chkValid(chkValid), .chkWrite(chkWrite), .chkAddr(chkAddr), .chkWdata(chkWdata), .chkCtrl(chkCtrl),
    .shRdValid(shRdValid), .shRdData(shRdData), .shRdPar(shRdPar),
    .outValid(outValid), .outWrite(outWrite), .outAddr(outAddr), .outWdata(outWdata), .outCtrl(outCtrl),
    .faultFlag(faultFlag), .faultClass(faultClass)
  );

  function automatic logic [LANES-1:0] evenPar(logic [DATA_W-1:0] d);
    logic [LANES-1:0] p;
    for (int i = 0; i < LANES; i++) p[i] = ^d[i*8 +: 8];
    return p;
  endfunction

  // Class expected from the current inputs, per R4-R7 and R11
  function automatic logic [2:0] cycleClass();
    logic both;
    logic parBad;
    both = mstValid && chkValid;
    parBad = shRdValid && (shRdPar != evenPar(shRdData));
    if (mstValid != chkValid) return 3'd3;
    if (both && (mstWrite != chkWrite || mstCtrl != chkCtrl)) return 3'd3;
    if (both && mstAddr != chkAddr) return 3'd1;
    if (both && mstWrite && mstWdata != chkWdata) return 3'd2;
    if (parBad) return 3'd4;
    return 3'd0;
  endfunction

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    nVec++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Inputs already set (after a negedge); check, step through one edge
  task automatic cycle(string req);
    logic [2:0] cur;
    logic sil;
    #1;
    cur = cycleClass();
    sil = expFault || (cur != 3'd0);
    check(req, "outValid", {63'd0, outValid}, {63'd0, mstValid && !sil});
    check(req, "outWrite", {63'd0, outWrite}, {63'd0, mstWrite && !sil});
    check(req, "outAddr", {32'd0, outAddr}, {32'd0, mstAddr});
    check(req, "outWdata", {32'd0, outWdata}, {32'd0, mstWdata});
    check(req, "outCtrl", {60'd0, outCtrl}, {60'd0, mstCtrl});
    check(req, "faultFlag", {63'd0, faultFlag}, {63'd0, expFault});
    check(req, "faultClass", {61'd0, faultClass}, {61'd0, expCls});
    @(posedge clk);
    if (!expFault && cur != 3'd0) begin
      expFault = 1'b1;
      expCls = cur;
    end
    @(negedge clk);
  endtask

  task automatic setMatch(logic v, logic w, logic [31:0] a, logic [31:0] d, logic [3:0] c);
    mstValid = v; chkValid = v; mstWrite = w; chkWrite = w;
    mstAddr = a; chkAddr = a; mstWdata = d; chkWdata = d; mstCtrl = c; chkCtrl = c;
    shRdValid = 1'b0; shRdData = d ^ 32'h5a5a_0f0f; shRdPar = evenPar(d ^ 32'h5a5a_0f0f);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    setMatch(1'b0, 1'b0, '0, '0, '0);
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    expFault = 1'b0;
    expCls = 3'd0;
  endtask

  initial begin
    #(8 * 200000);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
    $finish;
  end

  initial begin
    int unsigned seedv;
    seedv = $urandom(32'd2024);
    setMatch(1'b0, 1'b0, '0, '0, '0);
    doReset();

    // R1 reset state
    #1;
    check("R1", "faultFlag", {63'd0, faultFlag}, 64'd0);
    check("R1", "faultClass", {61'd0, faultClass}, 64'd0);

    // R2 matching write and read traffic
    setMatch(1'b1, 1'b1, 32'h1000_0040, 32'hdead_beef, 4'h3); cycle("R2");
    setMatch(1'b1, 1'b0, 32'h1000_0044, 32'h0, 4'h2); shRdValid = 1'b1;
    shRdData = 32'h0123_4567; shRdPar = evenPar(32'h0123_4567); cycle("R2");

    // R3 idle cycles with differing lines
    setMatch(1'b0, 1'b0, 32'h0, 32'h0, 4'h0);
    chkAddr = 32'hffff_ffff; chkWdata = 32'h1234_5678; chkCtrl = 4'hf; chkWrite = 1'b1;
    cycle("R3"); cycle("R3");

    // R5 read cycle: write data not compared
    setMatch(1'b1, 1'b0, 32'h2000_0000, 32'h1111_1111, 4'h1); chkWdata = 32'h2222_2222;
    cycle("R5"); cycle("R5");

    // R4 address mismatch, R8 same-cycle silence, R9 sticky
    setMatch(1'b1, 1'b1, 32'h3000_0000, 32'haaaa_5555, 4'h4); chkAddr = 32'h3000_0004;
    cycle("R8");
    setMatch(1'b1, 1'b1, 32'h3000_0008, 32'h5, 4'h4); cycle("R4");
    // R10 later control mismatch leaves class
    chkCtrl = 4'h9; cycle("R10");
    setMatch(1'b1, 1'b1, 32'h3000_000c, 32'h6, 4'h4); cycle("R9"); cycle("R9");

    doReset();
    setMatch(1'b1, 1'b1, 32'h4000_0000, 32'h0000_00ff, 4'h2); chkWdata = 32'h0000_01ff;
    cycle("R5");
    setMatch(1'b1, 1'b1, 32'h4000_0004, 32'h0, 4'h2); cycle("R5");

    doReset();
    setMatch(1'b1, 1'b0, 32'h5000_0000, 32'h0, 4'h0); chkValid = 1'b0;
    cycle("R6");
    setMatch(1'b0, 1'b0, 32'h0, 32'h0, 4'h0); cycle("R6");

    doReset();
    setMatch(1'b1, 1'b0, 32'h6000_0000, 32'h0, 4'h0); shRdValid = 1'b1;
    shRdData = 32'h00ff_0001; shRdPar = evenPar(32'h00ff_0001) ^ 4'b0100;
    cycle("R7");
    setMatch(1'b1, 1'b0, 32'h6000_0004, 32'h0, 4'h0); cycle("R7");

    // R11 address + data + parity at once -> address
    doReset();
    setMatch(1'b1, 1'b1, 32'h7000_0000, 32'h1, 4'h5);
    chkAddr = 32'h7000_0010; chkWdata = 32'h2; shRdValid = 1'b1; shRdPar = ~evenPar(shRdData);
    cycle("R11");
    setMatch(1'b0, 1'b0, 32'h0, 32'h0, 4'h0); cycle("R11");
    // R11 control + address -> control
    doReset();
    setMatch(1'b1, 1'b1, 32'h7100_0000, 32'h1, 4'h5); chkAddr = 32'h7100_0008; chkCtrl = 4'h6;
    cycle("R11");
    setMatch(1'b0, 1'b0, 32'h0, 32'h0, 4'h0); cycle("R11");

    // Constrained random traffic with rare faults
    doReset();
    for (int k = 0; k < 3000; k++) begin
      int unsigned r;
      setMatch($urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1, $urandom, $urandom, 4'($urandom));
      if ($urandom_range(0, 2) == 0) begin
        shRdValid = 1'b1;
        shRdData = $urandom;
        shRdPar = evenPar(shRdData);
        if ($urandom_range(0, 79) == 0) shRdPar[$urandom_range(0, LANES-1)] ^= 1'b1;
      end
      r = $urandom_range(0, 59);
      case (r)
        0: chkAddr[$urandom_range(0, ADDR_W-1)] ^= 1'b1;
        1: chkWdata[$urandom_range(0, DATA_W-1)] ^= 1'b1;
        2: chkCtrl[$urandom_range(0, CTRL_W-1)] ^= 1'b1;
        3: chkValid = ~chkValid;
        4: chkWrite = ~chkWrite;
        default: ;
      endcase
      cycle("R2");
      if (expFault && $urandom_range(0, 15) == 0) doReset();
    end

    $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
    $finish;
  end

endmodule